// File: doc/BRIEF.md
# Parallel SAD Motion Search Array

This block computes sum-of-absolute-difference scores for integer motion estimation. A small array of reference pixel rows sits in a shift register that can move every row up by one (taking a fresh bottom row from two 128-bit load ports) or slide every row left by one pixel. A 4x4 block of current pixels is held beside it. On a compute strobe, sixteen candidate positions are scored at once: candidate k places the current block over reference columns k to k+3 of the top four rows. That is 256 absolute differences in one cycle.

A controller outside the block sequences loads, shifts and compute strobes. Each compute yields all sixteen candidate sums and the best candidate, one cycle later. Horizontal neighbours share the pixels already held, and a vertical step needs only one new row. The controller therefore walks a search area with one row load or one shift for each new set of sixteen candidates.

Top module: `sad_search_array`

## Requirements
- R1: While rst_ni is low and after its release, valid_o is 0, every sad_o slot is 0, best_sad_o is 0 and best_idx_o is 0.
- R2: A vertical step (ref_vshift_i) moves reference row r+1 into row r and loads the bottom row from the load ports. Pixel j (0..15) comes from ref_lo_i[8j+7:8j] and pixel 16+j from ref_hi_i[8j+7:8j]. Pixel 0 is the leftmost column.
- R3: A horizontal step (ref_hshift_i without ref_vshift_i) makes every row's pixel j take the value of pixel j+1. The rightmost pixel (31) becomes 0.
- R4: When ref_vshift_i and ref_hshift_i are both high in one cycle, only the vertical step takes place.
- R5: cur_we_i loads the 4x4 current block from cur_block_i, where row r, column c is cur_block_i[8(4r+c)+7 : 8(4r+c)].
- R6: Candidate k (0..15) scores the sum over r,c in 0..3 of |cur[r][c] - ref[r][k+c]|, using the top four reference rows. It is reported on sad_o[12k+11:12k].
- R7: Results are registered. They appear on the clock edge after compute_i is sampled high, and valid_o is high for exactly that one cycle. In every other cycle, sad_o, best_sad_o and best_idx_o hold their last values.
- R8: best_sad_o is the smallest of the sixteen sums, and best_idx_o is its candidate index. On equal sums the lowest index wins.
- R9: compute_i is never high in a cycle in which ref_vshift_i, ref_hshift_i or cur_we_i is high.
- R10: A sum reaches 4080 (16 x 255) without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_vshift_i | input | 1 | Move reference rows up and load a new bottom row |
| ref_hshift_i | input | 1 | Slide all reference rows left by one pixel |
| ref_lo_i | input | 128 | New bottom row, pixels 0..15 |
| ref_hi_i | input | 128 | New bottom row, pixels 16..31 |
| cur_we_i | input | 1 | Load the current 4x4 block |
| cur_block_i | input | 128 | Current block, 16 pixels in row-major order |
| compute_i | input | 1 | Score all candidates |
| valid_o | output | 1 | Results updated this cycle |
| sad_o | output | 192 | Sixteen 12-bit candidate sums, candidate k in slot k |
| best_sad_o | output | 12 | Minimum sum |
| best_idx_o | output | 4 | Index of the minimum sum, lowest on ties |

## Verification
The hardest cases to reach from the ports are ties between candidates and the zero fill at the right edge of the rows. Random pixels almost never give equal sums. Zero-filled pixels only reach a candidate window after more than a dozen horizontal slides without a vertical reload. The stimulus runs a directed period-4 pattern that gives four equal minima, then shifts it by one column to move the winning index. It also runs random epochs that draw pixels from a narrow range and favour horizontal slides, so ties and zero columns occur often. Each compute is checked against a bench model of the row array.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int unsigned PIX_W    = 8;
  localparam int unsigned BLK      = 4;
  localparam int unsigned N_CAND   = 16;
  localparam int unsigned LOAD_PIX = 16;
  localparam int unsigned REF_ROWS = 4;
endpackage

// File: rtl/sad_ref_array.sv
module sad_ref_array #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned ROW_PIX = 32,
  parameter int unsigned ROWS    = 4,
  localparam int unsigned ROW_W  = ROW_PIX * PIX_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vshift_i,
  input  logic                  hshift_i,
  input  logic [ROW_W-1:0]      new_row_i,
  output logic [ROWS*ROW_W-1:0] rows_o
);
  logic [ROW_W-1:0] row_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) row_q[r] <= '0;
    end else if (vshift_i) begin
      for (int r = 0; r < ROWS - 1; r++) row_q[r] <= row_q[r+1];
      row_q[ROWS-1] <= new_row_i;
    end else if (hshift_i) begin
      for (int r = 0; r < ROWS; r++) row_q[r] <= row_q[r] >> PIX_W;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_out
    assign rows_o[r*ROW_W +: ROW_W] = row_q[r];
  end

  p_bottom_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vshift_i |=> row_q[ROWS-1] == $past(new_row_i));
  p_vshift_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vshift_i && hshift_i) |=> row_q[ROWS-1] == $past(new_row_i));
  p_edge_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hshift_i && !vshift_i) |=> row_q[0][ROW_W-PIX_W +: PIX_W] == '0);
  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hshift_i && !vshift_i) |=> $stable(row_q[0]) && $stable(row_q[ROWS-1]));
endmodule

// File: rtl/sad_cand.sv
module sad_cand #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned BLK   = 4,
  parameter int unsigned SAD_W = 12,
  localparam int unsigned NPIX = BLK * BLK
) (
  input  logic [NPIX*PIX_W-1:0] cur_i,
  input  logic [NPIX*PIX_W-1:0] win_i,
  output logic [SAD_W-1:0]      sad_o
);
  logic [SAD_W-1:0] row_sum [BLK];

  // One BLKx1 unit per row, then a row-sum reduction
  for (genvar r = 0; r < BLK; r++) begin : g_row
    always_comb begin
      logic [PIX_W-1:0] a, b, d;
      row_sum[r] = '0;
      for (int c = 0; c < BLK; c++) begin
        a = cur_i[(r*BLK+c)*PIX_W +: PIX_W];
        b = win_i[(r*BLK+c)*PIX_W +: PIX_W];
        d = (a > b) ? a - b : b - a;
        row_sum[r] = row_sum[r] + SAD_W'(d);
      end
    end
  end

  always_comb begin
    sad_o = '0;
    for (int r = 0; r < BLK; r++) sad_o = sad_o + row_sum[r];
  end
endmodule

// File: rtl/sad_min_select.sv
module sad_min_select #(
  parameter int unsigned N     = 16,
  parameter int unsigned SAD_W = 12,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*SAD_W-1:0] sads_i,
  output logic [SAD_W-1:0]   min_sad_o,
  output logic [IDX_W-1:0]   min_idx_o
);
  // Strict less-than keeps the lowest index on ties
  always_comb begin
    min_sad_o = sads_i[0 +: SAD_W];
    min_idx_o = '0;
    for (int k = 1; k < N; k++) begin
      if (sads_i[k*SAD_W +: SAD_W] < min_sad_o) begin
        min_sad_o = sads_i[k*SAD_W +: SAD_W];
        min_idx_o = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/sad_search_array.sv
module sad_search_array
  import sad_pkg::*;
#(
  parameter int unsigned PIX_W_P    = PIX_W,
  parameter int unsigned BLK_P      = BLK,
  parameter int unsigned N_CAND_P   = N_CAND,
  parameter int unsigned LOAD_PIX_P = LOAD_PIX,
  parameter int unsigned ROWS_P     = REF_ROWS,
  localparam int unsigned LOAD_W  = LOAD_PIX_P * PIX_W_P,
  localparam int unsigned ROW_PIX = 2 * LOAD_PIX_P,
  localparam int unsigned ROW_W   = ROW_PIX * PIX_W_P,
  localparam int unsigned NPIX    = BLK_P * BLK_P,
  localparam int unsigned MAX_SAD = NPIX * ((1 << PIX_W_P) - 1),
  localparam int unsigned SAD_W   = $clog2(MAX_SAD + 1),
  localparam int unsigned IDX_W   = (N_CAND_P > 1) ? $clog2(N_CAND_P) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ref_vshift_i,
  input  logic                      ref_hshift_i,
  input  logic [LOAD_W-1:0]         ref_lo_i,
  input  logic [LOAD_W-1:0]         ref_hi_i,
  input  logic                      cur_we_i,
  input  logic [NPIX*PIX_W_P-1:0]   cur_block_i,
  input  logic                      compute_i,
  output logic                      valid_o,
  output logic [N_CAND_P*SAD_W-1:0] sad_o,
  output logic [SAD_W-1:0]          best_sad_o,
  output logic [IDX_W-1:0]          best_idx_o
);
  logic [ROWS_P*ROW_W-1:0]     rows;
  logic [NPIX*PIX_W_P-1:0]     cur_q;
  logic [N_CAND_P*SAD_W-1:0]   sad_d;
  logic [SAD_W-1:0]            min_sad;
  logic [IDX_W-1:0]            min_idx;

  sad_ref_array #(
    .PIX_W  (PIX_W_P),
    .ROW_PIX(ROW_PIX),
    .ROWS   (ROWS_P)
  ) i_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vshift_i (ref_vshift_i),
    .hshift_i (ref_hshift_i),
    .new_row_i({ref_hi_i, ref_lo_i}),
    .rows_o   (rows)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cur_q <= '0;
    else if (cur_we_i) cur_q <= cur_block_i;
  end

  for (genvar k = 0; k < N_CAND_P; k++) begin : g_cand
    logic [NPIX*PIX_W_P-1:0] win;
    for (genvar r = 0; r < BLK_P; r++) begin : g_r
      for (genvar c = 0; c < BLK_P; c++) begin : g_c
        assign win[(r*BLK_P+c)*PIX_W_P +: PIX_W_P] =
          rows[r*ROW_W + (k+c)*PIX_W_P +: PIX_W_P];
      end
    end
    sad_cand #(
      .PIX_W(PIX_W_P),
      .BLK  (BLK_P),
      .SAD_W(SAD_W)
    ) i_cand (
      .cur_i(cur_q),
      .win_i(win),
      .sad_o(sad_d[k*SAD_W +: SAD_W])
    );
  end

  sad_min_select #(
    .N    (N_CAND_P),
    .SAD_W(SAD_W)
  ) i_min (
    .sads_i   (sad_d),
    .min_sad_o(min_sad),
    .min_idx_o(min_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      sad_o      <= '0;
      best_sad_o <= '0;
      best_idx_o <= '0;
    end else begin
      valid_o <= compute_i;
      if (compute_i) begin
        sad_o      <= sad_d;
        best_sad_o <= min_sad;
        best_idx_o <= min_idx;
      end
    end
  end

  p_no_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    compute_i |-> !(ref_vshift_i || ref_hshift_i || cur_we_i));
  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    compute_i |=> valid_o);
  p_valid_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !compute_i |=> !valid_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !compute_i |=> $stable(sad_o) && $stable(best_sad_o) && $stable(best_idx_o));
  p_best_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sad_o[best_idx_o*SAD_W +: SAD_W] == best_sad_o);

  for (genvar k = 0; k < N_CAND_P; k++) begin : g_chk
    p_min_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> ((IDX_W'(k) < best_idx_o) ? (sad_o[k*SAD_W +: SAD_W] > best_sad_o)
                                            : (sad_o[k*SAD_W +: SAD_W] >= best_sad_o)));
    p_no_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> 32'(sad_o[k*SAD_W +: SAD_W]) <= MAX_SAD);
  end
endmodule

// File: tb/test_sad_search_array.sv
module test_sad_search_array;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         vsh = 1'b0, hsh = 1'b0, cwe = 1'b0, cmp = 1'b0;
  logic [127:0] lo = '0, hi = '0, cblk = '0;
  logic         valid;
  logic [191:0] sad;
  logic [11:0]  best_sad;
  logic [3:0]   best_idx;

  int unsigned vectors = 0;
  int unsigned fails = 0;
  bit          done = 0;

  logic [7:0]  ref_m [4][32];
  logic [7:0]  cur_m [16];
  logic [11:0] last_sad [NC];
  logic [11:0] last_best;
  logic [3:0]  last_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  sad_search_array i_sad_search_array (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ref_vshift_i(vsh),
    .ref_hshift_i(hsh),
    .ref_lo_i    (lo),
    .ref_hi_i    (hi),
    .cur_we_i    (cwe),
    .cur_block_i (cblk),
    .compute_i   (cmp),
    .valid_o     (valid),
    .sad_o       (sad),
    .best_sad_o  (best_sad),
    .best_idx_o  (best_idx)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_sad(input int k);
    int s = 0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        int a = cur_m[r*4+c];
        int b = ref_m[r][k+c];
        s += (a > b) ? a - b : b - a;
      end
    return s;
  endfunction

  // Caller sits at a negedge; results are visible at the next negedge
  task automatic step(input bit v, input bit h, input bit we, input bit cp,
                      input logic [255:0] row, input logic [127:0] blk);
    vsh = v; hsh = h; cwe = we; cmp = cp;
    {hi, lo} = row; cblk = blk;
    if (cp) begin
      int bi = 0;
      for (int k = 0; k < NC; k++) begin
        last_sad[k] = 12'(exp_sad(k));
        if (last_sad[k] < last_sad[bi]) bi = k;
      end
      last_best = last_sad[bi];
      last_idx  = 4'(bi);
    end
    if (v) begin // R4: vertical wins
      for (int r = 0; r < 3; r++) ref_m[r] = ref_m[r+1];
      for (int j = 0; j < 32; j++) ref_m[3][j] = row[j*8 +: 8];
    end else if (h) begin
      for (int r = 0; r < 4; r++) begin
        for (int j = 0; j < 31; j++) ref_m[r][j] = ref_m[r][j+1];
        ref_m[r][31] = 8'd0;
      end
    end
    if (we) for (int p = 0; p < 16; p++) cur_m[p] = blk[p*8 +: 8];
    @(negedge clk);
    vsh = 0; hsh = 0; cwe = 0; cmp = 0;
    chk("R7", "valid_o", int'(valid), int'(cp));
    for (int k = 0; k < NC; k++)
      chk(cp ? "R6" : "R7", $sformatf("sad[%0d]", k), int'(sad[k*12 +: 12]), int'(last_sad[k]));
    chk("R8", "best_sad_o", int'(best_sad), int'(last_best));
    chk("R8", "best_idx_o", int'(best_idx), int'(last_idx));
  endtask

  function automatic logic [7:0] rpix(input bit narrow);
    return narrow ? 8'($urandom % 4) : 8'($urandom % 256);
  endfunction

  function automatic logic [255:0] rand_row(input bit narrow);
    logic [255:0] x;
    for (int j = 0; j < 32; j++) x[j*8 +: 8] = rpix(narrow);
    return x;
  endfunction

  function automatic logic [127:0] rand_blk(input bit narrow);
    logic [127:0] x;
    for (int j = 0; j < 16; j++) x[j*8 +: 8] = rpix(narrow);
    return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [255:0] row;
    logic [127:0] blk;
    void'($urandom(32'h5ad0_1e57));
    for (int r = 0; r < 4; r++) for (int j = 0; j < 32; j++) ref_m[r][j] = 0;
    for (int p = 0; p < 16; p++) cur_m[p] = 0;
    for (int k = 0; k < NC; k++) last_sad[k] = 0;
    last_best = 0; last_idx = 0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "valid_o in reset", int'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid_o", int'(valid), 0);
    chk("R1", "sad_o nonzero", int'(sad != '0), 0);
    chk("R1", "best_sad_o", int'(best_sad), 0);
    chk("R1", "best_idx_o", int'(best_idx), 0);

    // R10: 255 vs 0 everywhere -> 4080, all tied -> index 0
    step(0, 0, 1, 0, '0, {16{8'hff}});
    step(0, 0, 0, 1, '0, '0);
    chk("R10", "max sum", int'(sad[15*12 +: 12]), 4080);

    // R8: period-4 pattern gives ties at 0,4,8,12, then 3,7,11,15 after one slide
    for (int j = 0; j < 32; j++) row[j*8 +: 8] = 8'((j % 4) * 10 + 5);
    for (int j = 0; j < 16; j++) blk[j*8 +: 8] = 8'((j % 4) * 10 + 5);
    for (int r = 0; r < 4; r++) step(1, 0, 0, 0, row, '0);   // R2
    step(0, 0, 1, 0, '0, blk);                               // R5
    step(0, 0, 0, 1, '0, '0);
    chk("R8", "tie lowest", int'(best_idx), 0);
    step(0, 1, 0, 0, '0, '0);                                // R3
    step(0, 0, 0, 1, '0, '0);
    chk("R8", "tie after slide", int'(best_idx), 3);
    // R4: both strobes -> vertical only
    step(1, 1, 0, 0, rand_row(0), '0);
    step(0, 0, 0, 1, '0, '0);

    // Random epochs; narrow epochs favour ties and edge zero fill
    for (int e = 0; e < 8; e++) begin
      bit narrow = e[0];
      for (int i = 0; i < 60; i++) begin
        int op = $urandom % 10;
        if (op < 2)       step(1, 0, 0, 0, rand_row(narrow), '0);
        else if (op < 4 || (narrow && op < 6)) step(0, 1, 0, 0, '0, '0);
        else if (op < 5)  step(1, 1, 0, 0, rand_row(narrow), '0);
        else if (op < 7)  step(0, 0, 1, 0, '0, rand_blk(narrow));
        else              step(0, 0, 0, 1, '0, '0);
      end
    end

    // R3: long slide run pushes zero fill into every window
    for (int i = 0; i < 20; i++) step(0, 1, 0, 0, '0, '0);
    step(0, 0, 0, 1, '0, '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule